// File: doc/BRIEF.md
# Up/Down Event Counter with Sticky Status and Interrupt

This block counts events from two asynchronous inputs into a 32-bit wrapping counter. It also keeps a small set of sticky event flags that software can read. The two inputs are first passed through a two-flop synchronizer. A decoder then turns the synchronized pair into increment, decrement or illegal-code events. How it does this depends on the selected mode:

- **Up/down counting:** rising edges on each input count separately.
- **Quadrature:** the pair is read as a Gray-coded position.
- **Binary:** the pair is read as a 2-bit binary position.
- **Direction-timer:** the counter steps on every clock, and the level of the down input picks the direction.

Each event sets its own status flag. A flag stays set until software writes a one to its bit position, or until the block is disabled. The increment and decrement flags record that a step happened, not the net direction of travel, so both can be set at once. Each flag has a matching enable bit in a mask register. The interrupt request is high when any flag is set together with its enable bit. Software reaches the block through a one-cycle register write strobe and a combinational read port, addressed by a 2-bit index.

Top module: `updn_event_counter`

## Requirements
- R1: After reset, the control, status, mask and count registers all read zero and `irq` is low.
- R2: Register map: address 0 is control (bit 0 enable, bits 2:1 mode, with 0 = up/down, 1 = quadrature, 2 = binary, 3 = direction-timer). Address 1 is status (bit 0 increment, bit 1 decrement, bit 2 illegal). Address 2 is the mask (same bit layout as status). Address 3 is the count, which is read-only. In up/down mode, a rising edge on `in_up` adds one and a rising edge on `in_dn` subtracts one. The new count is readable on the third rising clock edge after the input changes.
- R3: In up/down mode, if rising edges on both inputs reach the decoder in the same cycle, the count is unchanged and both the increment and decrement flags are set.
- R4: The increment and decrement flags latch independently of the net change. For example, one increment followed by two decrements leaves status = 3.
- R5: Writing to status clears every bit written as one. Bits written as zero keep their value. Status never clears on its own while the block is enabled.
- R6: If a hardware event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R7: While enable is low, the status register is held at zero and the count does not change. The count keeps its value across disable and re-enable.
- R8: In quadrature mode, with the pair read as {in_up, in_dn}, the code sequence 00, 01, 11, 10 counts up and the reverse counts down. A change of both bits in one sampled cycle sets the illegal flag and leaves the count unchanged.
- R9: In binary mode, {in_up, in_dn} is a 2-bit value. A change of +1 or -1 modulo 4 counts in that direction. A change of 2 sets the illegal flag and leaves the count unchanged.
- R10: In direction-timer mode, the count changes by one on every clock. It rises while the synchronized `in_dn` is low and falls while it is high, and the matching flag is set.
- R11: `irq` is high exactly when at least one status bit is set together with its mask bit.
- R12: The count wraps modulo 2^32 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_up | input | 1 | Asynchronous up / A-phase / code MSB input |
| in_dn | input | 1 | Asynchronous down / B-phase / code LSB / direction input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register index |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register index |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
A change on an input needs three rising edges before it shows up: two synchronizer stages, then the counter and status update. Status and `irq` follow on that same edge, while register writes take effect on the first edge after the strobe. Each scenario drives its inputs on a falling edge and samples one falling edge after the update is due. One test checks that the count is still unchanged at the second falling edge and has changed by the third. The same-cycle set-versus-clear case places the write strobe so that it lands exactly on the third edge after the input change.

// File: rtl/updn_evt_pkg.sv
package updn_evt_pkg;

    typedef enum logic [1:0] {
        MODE_UPDN = 2'd0,
        MODE_QUAD = 2'd1,
        MODE_BIN  = 2'd2,
        MODE_DIRT = 2'd3
    } cnt_mode_e;

    localparam int NUM_EVT = 3;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] REG_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] REG_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] REG_MASK   = 2'd2;
    localparam logic [ADDR_W-1:0] REG_COUNT  = 2'd3;

    // bit order matches the status register: ill=2, dec=1, inc=0
    typedef struct packed {
        logic ill;
        logic dec;
        logic inc;
    } evt_t;

    // Position on the 4-step wheel for the two code-based modes
    function automatic logic [1:0] code_pos(cnt_mode_e m, logic [1:0] ab);
        if (m == MODE_QUAD)
            return {ab[1], ab[1] ^ ab[0]};
        return ab;
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/evt_decode.sv
module evt_decode
    import updn_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cnt_mode_e  mode,
    input  logic [1:0] ab_s,
    output evt_t       evt
);
    logic [1:0] prev_q;
    logic [1:0] rise;
    logic [1:0] cur_p;
    logic [1:0] prv_p;
    logic [1:0] delta;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= ab_s;
    end

    always_comb begin
        evt   = '0;
        rise  = ab_s & ~prev_q;
        cur_p = code_pos(mode, ab_s);
        prv_p = code_pos(mode, prev_q);
        delta = cur_p - prv_p;
        case (mode)
            MODE_UPDN: begin
                evt.inc = rise[1];
                evt.dec = rise[0];
            end
            MODE_QUAD, MODE_BIN: begin
                evt.inc = (delta == 2'd1);
                evt.dec = (delta == 2'd3);
                evt.ill = (delta == 2'd2);
            end
            default: begin
                evt.inc = ~ab_s[0];
                evt.dec = ab_s[0];
            end
        endcase
    end
endmodule

// File: rtl/evt_counter.sv
module evt_counter
    import updn_evt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  evt_t             evt,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (en && evt.inc && !evt.dec)
            cnt_q <= cnt_q + ONE;
        else if (en && evt.dec && !evt.inc)
            cnt_q <= cnt_q - ONE;
    end

    assign count = cnt_q;
endmodule

// File: rtl/updn_event_counter.sv
module updn_event_counter
    import updn_evt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_up,
    input  logic              in_dn,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    logic [1:0]         ab_s;
    evt_t               evt;
    logic [NUM_EVT-1:0] evt_vec;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] status_q;
    logic [NUM_EVT-1:0] mask_q;
    logic               en_q;
    cnt_mode_e          mode_q;
    logic [CNT_W-1:0]   count;
    logic               unused_wr_hi;

    assign unused_wr_hi = ^wr_data[CNT_W-1:NUM_EVT];

    evt_sync #(.W(2)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .d_async ({in_up, in_dn}),
        .d_sync  (ab_s)
    );

    evt_decode dec_i (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_q),
        .ab_s (ab_s),
        .evt  (evt)
    );

    evt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .en    (en_q),
        .evt   (evt),
        .count (count)
    );

    assign evt_vec = evt;
    assign clr_vec = (wr_en && wr_addr == REG_STATUS) ? wr_data[NUM_EVT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mode_q <= MODE_UPDN;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_CTRL) begin
                en_q   <= wr_data[0];
                mode_q <= cnt_mode_e'(wr_data[2:1]);
            end
            if (wr_addr == REG_MASK)
                mask_q <= wr_data[NUM_EVT-1:0];
        end
    end

    // event set takes priority over a same-cycle software clear
    always_ff @(posedge clk) begin
        if (rst || !en_q)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_vec) | evt_vec;
    end

    assign irq = |(status_q & mask_q);

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CTRL: begin
                rd_data[0]   = en_q;
                rd_data[2:1] = mode_q;
            end
            REG_STATUS: rd_data[NUM_EVT-1:0] = status_q;
            REG_MASK:   rd_data[NUM_EVT-1:0] = mask_q;
            default:    rd_data = count;
        endcase
    end
endmodule

// File: rtl/updn_event_counter_chk.sv
module updn_event_counter_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [CNT_W-1:0] count,
    input logic [2:0]       status,
    input logic [2:0]       evt_vec,
    input logic [2:0]       clr,
    input logic             irq
);
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!en || evt_vec[1:0] == 2'b00) |=> $stable(count));

    assert_dual_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_vec[0] && evt_vec[1]) |=> $stable(count));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (en && evt_vec == 3'b000 && clr == 3'b000) |=> $stable(status));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (en && evt_vec != 3'b000) |=> ((status & $past(evt_vec)) == $past(evt_vec)));

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (status == 3'b000));

    assert_illegal_hold_R8: assert property (@(posedge clk) disable iff (rst)
        evt_vec[2] |=> $stable(count));

    assert_disabled_irq_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> !irq);
endmodule

bind updn_event_counter updn_event_counter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en_q),
    .count   (count),
    .status  (status_q),
    .evt_vec (evt_vec),
    .clr     (clr_vec),
    .irq     (irq)
);

// File: tb/updn_event_counter_tb.sv
`timescale 1ns/1ps
module updn_event_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_up = 1'b0;
    logic        in_dn = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    updn_event_counter dut_i (
        .clk(clk), .rst(rst), .in_up(in_up), .in_dn(in_dn),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitn(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_up = 1'b0; in_dn = 1'b0; wr_en = 1'b0;
        waitn(3);
        rst = 1'b0;
        waitn(1);
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_ab(logic u, logic d);
        in_up = u; in_dn = d;
        waitn(4);
    endtask

    task automatic pulse_up();
        set_ab(1'b1, in_dn);
        set_ab(1'b0, in_dn);
    endtask

    task automatic pulse_dn();
        set_ab(in_up, 1'b1);
        set_ab(in_up, 1'b0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        for (int a = 0; a < 4; a++) begin
            rd_reg(a[1:0], v);
            check("R1 reg zero", v, 32'd0);
        end
        check("R1 irq low", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_updn();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd0, 32'h1);
        rd_reg(2'd0, v);
        check("R2 ctrl readback", v, 32'h1);
        in_up = 1'b1;
        waitn(2);
        rd_reg(2'd3, v);
        check("R2 not yet counted", v, 32'd0);
        waitn(1);
        rd_reg(2'd3, v);
        check("R2 counted on third edge", v, 32'd1);
        in_up = 1'b0;
        waitn(4);
        pulse_dn();
        pulse_dn();
        rd_reg(2'd3, v);
        check("R12 wrap below zero", v, 32'hFFFF_FFFF);
        rd_reg(2'd1, v);
        check("R4 both flags", v, 32'h3);
        wr_reg(2'd1, 32'h0);
        rd_reg(2'd1, v);
        check("R5 zero write keeps", v, 32'h3);
        wr_reg(2'd1, 32'h1);
        rd_reg(2'd1, v);
        check("R5 clear inc only", v, 32'h2);
        wr_reg(2'd1, 32'h2);
        rd_reg(2'd1, v);
        check("R5 clear dec", v, 32'h0);
        wr_reg(2'd3, 32'h1234);
        rd_reg(2'd3, v);
        check("R2 count read-only", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_dual();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd0, 32'h1);
        set_ab(1'b1, 1'b1);
        rd_reg(2'd3, v);
        check("R3 count held", v, 32'd0);
        rd_reg(2'd1, v);
        check("R3 both flags", v, 32'h3);
        set_ab(1'b0, 1'b0);
        do_reset();
        wr_reg(2'd0, 32'h1);
        pulse_dn();
        pulse_up();
        rd_reg(2'd3, v);
        check("R12 wrap above max", v, 32'd0);
    endtask

    task automatic t_setwins();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd0, 32'h1);
        in_up = 1'b1;
        waitn(2);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        rd_reg(2'd1, v);
        check("R6 set beats clear", v, 32'h1);
        wr_reg(2'd1, 32'h1);
        rd_reg(2'd1, v);
        check("R5 plain clear", v, 32'h0);
        in_up = 1'b0;
        waitn(4);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd0, 32'h1);
        pulse_up();
        wr_reg(2'd0, 32'h0);
        waitn(1);
        rd_reg(2'd1, v);
        check("R7 disable clears", v, 32'h0);
        pulse_up();
        rd_reg(2'd3, v);
        check("R7 no count disabled", v, 32'd1);
        rd_reg(2'd1, v);
        check("R7 no flag disabled", v, 32'h0);
        wr_reg(2'd0, 32'h1);
        waitn(1);
        rd_reg(2'd1, v);
        check("R7 re-enable clean", v, 32'h0);
        rd_reg(2'd3, v);
        check("R7 count kept", v, 32'd1);
    endtask

    task automatic t_quad();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd0, 32'h3);
        set_ab(1'b0, 1'b1);
        set_ab(1'b1, 1'b1);
        set_ab(1'b1, 1'b0);
        set_ab(1'b0, 1'b0);
        rd_reg(2'd3, v);
        check("R8 gray forward", v, 32'd4);
        rd_reg(2'd1, v);
        check("R8 inc only", v, 32'h1);
        set_ab(1'b1, 1'b0);
        rd_reg(2'd3, v);
        check("R8 gray reverse", v, 32'd3);
        set_ab(1'b0, 1'b1);
        rd_reg(2'd3, v);
        check("R8 illegal holds count", v, 32'd3);
        rd_reg(2'd1, v);
        check("R8 illegal flag", v, 32'h7);
    endtask

    task automatic t_bin();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd0, 32'h5);
        set_ab(1'b0, 1'b1);
        set_ab(1'b1, 1'b0);
        set_ab(1'b1, 1'b1);
        set_ab(1'b0, 1'b0);
        rd_reg(2'd3, v);
        check("R9 binary forward wrap", v, 32'd4);
        rd_reg(2'd1, v);
        check("R9 inc only", v, 32'h1);
        set_ab(1'b1, 1'b1);
        rd_reg(2'd3, v);
        check("R9 binary back", v, 32'd3);
        set_ab(1'b0, 1'b1);
        rd_reg(2'd3, v);
        check("R9 jump of two holds", v, 32'd3);
        rd_reg(2'd1, v);
        check("R9 illegal flag", v, 32'h7);
    endtask

    task automatic t_dirt();
        logic [31:0] a;
        logic [31:0] b;
        do_reset();
        wr_reg(2'd0, 32'h7);
        waitn(2);
        rd_reg(2'd3, a);
        waitn(1);
        rd_reg(2'd3, b);
        check("R10 up each clock", b - a, 32'd1);
        rd_reg(2'd1, a);
        check("R10 inc flag", a, 32'h1);
        in_dn = 1'b1;
        waitn(4);
        rd_reg(2'd3, a);
        waitn(1);
        rd_reg(2'd3, b);
        check("R10 down each clock", b - a, 32'hFFFF_FFFF);
        rd_reg(2'd1, a);
        check("R10 dec flag", a, 32'h3);
        wr_reg(2'd0, 32'h0);
        in_dn = 1'b0;
        waitn(4);
    endtask

    task automatic t_irq();
        do_reset();
        wr_reg(2'd0, 32'h1);
        wr_reg(2'd2, 32'h2);
        pulse_up();
        check("R11 unmasked inc no irq", {31'd0, irq}, 32'd0);
        pulse_dn();
        check("R11 masked dec irq", {31'd0, irq}, 32'd1);
        wr_reg(2'd2, 32'h4);
        check("R11 other mask no irq", {31'd0, irq}, 32'd0);
        wr_reg(2'd2, 32'h1);
        check("R11 inc mask irq", {31'd0, irq}, 32'd1);
        wr_reg(2'd1, 32'h7);
        check("R11 cleared no irq", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_updn();
        t_dual();
        t_setwins();
        t_disable();
        t_quad();
        t_bin();
        t_dirt();
        t_irq();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule